// File: doc/BRIEF.md
# Serial Slave Memory Read Controller

This block is the read side of a two-wire serial slave. A bus master uses it to read bytes from a memory array held inside the block. The block watches the clock and data lines with its own system clock. It finds start and stop conditions and compares a 7-bit device address. The master then sends a two-byte word address, which is loaded into an internal address counter.

Three read forms are supported. In a random read, the master writes the word address and then issues a repeated start and a read request. In a current-address read, the master sends a read request straight away. A sequential read is either of these in which the master acknowledges each byte to get the next one. The master can also load the counter without reading anything: it writes the word address and then issues a stop. The counter walks across the whole array and wraps from the last address back to address zero.

The slave only ever pulls the data line low, through a registered output enable. The memory is a register array that reset fills with a fixed pattern, so every address has a known value.

Top module: `i2c_rd_slave`

## Requirements
- R1: After reset, the slave leaves SDA released (`sda_oe` = 0), is idle, and its address counter is 0, so a first current-address read returns the byte at address 0.
- R2: A stop (SDA rising while SCL is high) sends the slave to idle. Until the next start (SDA falling while SCL is high), no sequence of clock pulses makes it acknowledge or drive SDA.
- R3: The first byte after a start is taken MSB first on rising SCL edges. Bits 7..1 are the device address (default 7'h50) and bit 0 is read (1) or write (0). On a match, the slave acknowledges by holding SDA low for the ninth clock. On a mismatch it gives no acknowledge and stays idle until the next start.
- R4: After a write-direction device byte, the slave takes two word-address bytes, high byte first, and acknowledges each one. The counter is loaded with the low ADDR_W bits (default 9) of the 16-bit value, and higher bits are ignored.
- R5: A repeated start and a read-direction device byte after the word address make the slave acknowledge and then send the byte at the loaded address, MSB first.
- R6: A stop right after the word address loads the counter and returns no data. A later current-address read returns the byte at that address.
- R7: Each master acknowledge (SDA low on the ninth clock) after a data byte makes the slave send the byte at the next address.
- R8: The counter wraps from address 2^ADDR_W-1 to address 0 during a sequential read.
- R9: The counter moves one step past each byte sent. After a master no-acknowledge and a stop, the next current-address read returns the byte after the last one sent.
- R10: After reset, memory byte i holds ((i mod 256) XOR 0x5A) + (i div 256) mod 256.
- R11: The slave changes its SDA drive only while SCL is low.
- R12: A start in the middle of a byte abandons that transfer, and the bytes that follow are decoded as a fresh device byte.
- R13: A third byte written after the word address is not acknowledged and does not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level, as seen on the wired bus |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
Assertions check four rules on every cycle: the SDA drive changes only while SCL is low; a stop always leaves the slave idle with SDA released; SDA stays released while the slave is idle or ignoring bytes; and each master acknowledge moves the counter by exactly one, wrapping at the top. Directed scenarios are needed for the rest:
- the returned data values;
- two-byte address loading and the discarding of its upper bits;
- the set-address and current-address forms;
- wrap-around during a burst;
- device-address mismatch;
- abort by a start in the middle of a byte;
- a third write byte that is ignored.

// File: rtl/i2cr_pkg.sv
// Package: shared types and the memory fill pattern for the serial read slave.
// Assumes: byte-wide transfers and a word address of at most 16 bits.
package i2cr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,   // waiting for a start
        ST_RX,     // shifting in a byte from the master
        ST_ACK,    // holding SDA low for the ninth clock
        ST_TX,     // shifting out a data byte
        ST_MACK,   // sampling the master acknowledge
        ST_HOLD    // ignoring bytes until the next start or stop
    } xfer_state_t;

    typedef enum logic [1:0] {
        RB_DEV,    // device address byte
        RB_AHI,    // word address, high byte
        RB_ALO     // word address, low byte
    } rx_kind_t;

    // Pattern that reset loads into memory location a.
    function automatic logic [7:0] init_byte(input logic [31:0] a);
        return (a[7:0] ^ 8'h5A) + a[15:8];
    endfunction

endpackage

// File: rtl/i2cr_bus_cond.sv
// Module: samples the two bus lines into the system clock domain and reports
// the edges of SCL and the start and stop conditions as one-cycle strobes.
// Assumes: clk runs at least 8 times faster than SCL; both lines idle high.
module i2cr_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_m, scl_s, scl_p;
    logic sda_m, sda_s, sda_p;

    // Two-stage synchronizers plus one history stage for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            {scl_m, scl_s, scl_p} <= 3'b111;
            {sda_m, sda_s, sda_p} <= 3'b111;
        end else begin
            {scl_m, scl_s, scl_p} <= {scl_i, scl_m, scl_s};
            {sda_m, sda_s, sda_p} <= {sda_i, sda_m, sda_s};
        end
    end

    assign scl_lvl   = scl_s;
    assign sda_lvl   = sda_s;
    assign scl_rise  = scl_s & ~scl_p;
    assign scl_fall  = ~scl_s & scl_p;
    assign start_det = scl_s & scl_p & sda_p & ~sda_s;
    assign stop_det  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2cr_mem.sv
// Module: byte array with one registered read port. There is no write path;
// reset loads every location with init_byte(address).
// Assumes: the address is stable for two clocks before its data is used.
module i2cr_mem #(
    parameter int ADDR_W = 9,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] rdata
);
    import i2cr_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Fill the array on reset; otherwise register the addressed byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= DATA_W'(init_byte(32'(i)));
            end
            rdata <= '0;
        end else begin
            rdata <= mem[addr];
        end
    end

endmodule

// File: rtl/i2c_rd_slave.sv
// Module: read-only serial slave. It decodes the device byte and the two
// word-address bytes, loads the address counter, and returns memory bytes
// for as long as the master acknowledges them. SDA is driven only low.
// Assumes: the master changes SDA only while SCL is low; no clock stretching.
module i2c_rd_slave #(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    import i2cr_pkg::*;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);
    localparam int WORD_W = 2 * BYTE_W;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [BYTE_W-1:0] rdata;

    xfer_state_t       state;
    rx_kind_t          kind;
    logic [BYTE_W-1:0] shreg;
    logic [BYTE_W-1:0] addr_hi;
    logic [CNT_W-1:0]  bit_cnt;
    logic              full;
    logic              go_tx;
    logic              m_ack;
    logic [ADDR_W-1:0] addr_cnt;
    logic [WORD_W-1:0] word_addr;

    assign word_addr = {addr_hi, shreg};

    i2cr_bus_cond u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cr_mem #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr_cnt),
        .rdata (rdata)
    );

    // Transfer sequencer: bus conditions first, then per-state bit handling.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            kind     <= RB_DEV;
            shreg    <= '0;
            addr_hi  <= '0;
            bit_cnt  <= '0;
            full     <= 1'b0;
            go_tx    <= 1'b0;
            m_ack    <= 1'b0;
            addr_cnt <= '0;
            sda_oe   <= 1'b0;
        end else if (start_det) begin
            state   <= ST_RX;
            kind    <= RB_DEV;
            bit_cnt <= '0;
            full    <= 1'b0;
            sda_oe  <= 1'b0;
        end else if (stop_det) begin
            state   <= ST_IDLE;
            bit_cnt <= '0;
            full    <= 1'b0;
            sda_oe  <= 1'b0;
        end else begin
            case (state)
                ST_RX: begin
                    if (scl_rise && !full) begin
                        shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == CNT_W'(BYTE_W - 1)) full <= 1'b1;
                    end else if (scl_fall && full) begin
                        full    <= 1'b0;
                        bit_cnt <= '0;
                        case (kind)
                            RB_DEV: begin
                                if (shreg[BYTE_W-1:1] == DEV_ADDR) begin
                                    go_tx  <= shreg[0];
                                    sda_oe <= 1'b1;
                                    state  <= ST_ACK;
                                end else begin
                                    state  <= ST_IDLE;
                                end
                            end
                            RB_AHI: begin
                                addr_hi <= shreg;
                                sda_oe  <= 1'b1;
                                state   <= ST_ACK;
                            end
                            default: begin
                                addr_cnt <= word_addr[ADDR_W-1:0];
                                sda_oe   <= 1'b1;
                                state    <= ST_ACK;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        if (kind == RB_DEV && go_tx) begin
                            shreg    <= rdata << 1;
                            sda_oe   <= ~rdata[BYTE_W-1];
                            addr_cnt <= addr_cnt + 1'b1;
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else begin
                            sda_oe <= 1'b0;
                            case (kind)
                                RB_DEV:  begin kind <= RB_AHI; state <= ST_RX; end
                                RB_AHI:  begin kind <= RB_ALO; state <= ST_RX; end
                                default: state <= ST_HOLD;
                            endcase
                        end
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (scl_fall) begin
                        if (bit_cnt == CNT_W'(BYTE_W)) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe <= ~shreg[BYTE_W-1];
                            shreg  <= shreg << 1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_lvl;
                    end else if (scl_fall) begin
                        if (m_ack) begin
                            shreg    <= rdata << 1;
                            sda_oe   <= ~rdata[BYTE_W-1];
                            addr_cnt <= addr_cnt + 1'b1;
                            bit_cnt  <= '0;
                            state    <= ST_TX;
                        end else begin
                            state <= ST_HOLD;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    // R11: the slave moves SDA only in a cycle that follows SCL low.
    p_sda_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_lvl));

    // R2: a stop always ends in idle with the line released.
    p_stop_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE && !sda_oe));

    // R3, R13: no drive while idle (including after a mismatch) or while ignoring bytes.
    p_quiet_released_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE || state == ST_HOLD) |-> !sda_oe);

    // R7, R8: each master acknowledge moves the counter by exactly one (modulo the space).
    p_addr_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_MACK && scl_fall && m_ack && !start_det && !stop_det)
        |=> addr_cnt == $past(addr_cnt) + 1'b1);

endmodule

// File: tb/tb_i2c_rd_slave.sv
// Bench: directed scenarios that act as the bus master, one task for each.
// Each task checks its own results.
module tb_i2c_rd_slave;

    localparam int CLK_PERIOD = 10;
    localparam int QTR        = 10;
    localparam int AW         = 9;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1;
    logic m_sda = 1'b1;
    logic sda_oe;
    logic sda_bus;

    int n_chk = 0;
    int n_bad = 0;
    int exp_ptr = 0;
    bit done = 1'b0;

    assign sda_bus = m_sda & ~sda_oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    i2c_rd_slave #(.DEV_ADDR(7'h50), .ADDR_W(AW)) dut (
        .clk    (clk),
        .rst_n  (rst_n),
        .scl_i  (m_scl),
        .sda_i  (sda_bus),
        .sda_oe (sda_oe)
    );

    // Memory value at address a, worked out from R10.
    function automatic logic [7:0] exp_byte(input int a);
        int m;
        m = a % (1 << AW);
        return 8'((m % 256) ^ 8'h5A) + 8'(m / 256);
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic wq();
        repeat (QTR) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b0; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; wq();
        m_scl = 1'b1; wq();
        m_sda = 1'b1; wq(); wq();
    endtask

    task automatic put_bit(input bit b);
        m_sda = b;    wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic put_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) put_bit(b[i]);
        m_sda = 1'b1; wq();
        m_scl = 1'b1; wq();
        acked = !sda_bus; wq();
        m_scl = 1'b0; wq();
    endtask

    task automatic get_byte(input bit mack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; wq();
            m_scl = 1'b1; wq();
            d[i] = sda_bus; wq();
            m_scl = 1'b0; wq();
        end
        m_sda = !mack; wq();
        m_scl = 1'b1; wq(); wq();
        m_scl = 1'b0; wq();
        m_sda = 1'b1;
    endtask

    // Start, write-direction device byte, then the two word-address bytes.
    task automatic addr_phase(input logic [15:0] wa, input string tag);
        bit a;
        bus_start();
        put_byte(8'hA0, a);     check({tag, " R3 device ack"}, a, 1);
        put_byte(wa[15:8], a);  check({tag, " R4 high ack"}, a, 1);
        put_byte(wa[7:0], a);   check({tag, " R4 low ack"}, a, 1);
    endtask

    // Read n bytes with the read-direction device byte already sent.
    task automatic read_n(input int n, input int first, input string tag);
        logic [7:0] d;
        for (int k = 0; k < n; k++) begin
            get_byte(k < n - 1, d);
            check(tag, d, exp_byte(first + k));
        end
        exp_ptr = (first + n) % (1 << AW);
    endtask

    task automatic cur_read(input int n, input string tag);
        bit a;
        bus_start();
        put_byte(8'hA1, a);
        check({tag, " R3 read ack"}, a, 1);
        read_n(n, exp_ptr, tag);
        bus_stop();
    endtask

    task automatic rand_read(input logic [15:0] wa, input int n, input string tag);
        bit a;
        addr_phase(wa, tag);
        bus_start();
        put_byte(8'hA1, a);
        check({tag, " R5 read ack"}, a, 1);
        read_n(n, int'(wa) % (1 << AW), tag);
        bus_stop();
    endtask

    task automatic t_reset();
        check("R1 sda released after reset", sda_oe, 0);
        exp_ptr = 0;
        cur_read(1, "R1 R10 first read at address 0");
    endtask

    task automatic t_random();
        rand_read(16'h0137, 1, "R5 random read 0x137");
        cur_read(1, "R9 counter past last byte");
    endtask

    task automatic t_set_addr();
        addr_phase(16'h00A5, "R6");
        bus_stop();
        exp_ptr = 16'h0A5;
        cur_read(2, "R6 set address then current read");
    endtask

    task automatic t_sequential();
        rand_read(16'h00FD, 5, "R7 sequential across 0x100");
    endtask

    task automatic t_wrap();
        rand_read(16'hF3FE, 4, "R8 wrap to 0, R4 upper bits ignored");
    endtask

    task automatic t_mismatch();
        bit a;
        int keep;
        keep = exp_ptr;
        bus_start();
        put_byte(8'hA2, a);
        check("R3 mismatch gives no ack", a, 0);
        put_byte(8'hA1, a);
        check("R3 ignored until start", a, 0);
        bus_stop();
        exp_ptr = keep;
        cur_read(1, "R3 counter untouched by mismatch");
    endtask

    task automatic t_stop_ignore();
        bit a;
        put_byte(8'hA1, a);
        check("R2 no ack after stop without start", a, 0);
        put_byte(8'hA0, a);
        check("R2 still ignored", a, 0);
        bus_stop();
    endtask

    task automatic t_abort();
        bus_start();
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        rand_read(16'h0040, 2, "R12 read after mid-byte start");
    endtask

    task automatic t_extra_byte();
        bit a;
        addr_phase(16'h0010, "R13");
        put_byte(8'h99, a);
        check("R13 third write byte not acked", a, 0);
        bus_stop();
        exp_ptr = 16'h010;
        cur_read(1, "R13 counter keeps loaded address");
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        t_reset();
        t_random();
        t_set_addr();
        t_sequential();
        t_wrap();
        t_mismatch();
        t_stop_ignore();
        t_abort();
        t_extra_byte();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(negedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
        end
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule